// File: doc/BRIEF.md
# Round Phase Countdown Timer

This block times each phase of a quiz round. A round controller pulses `load` and picks one of two phases with `phase_sel`. The first phase is the window in which contestants may buzz in, 10 seconds by default. The second is the window a winning contestant has to answer, 30 seconds by default. The timer then counts the remaining whole seconds down to zero. The count is held as two decimal digits, so a display can show it directly.

Seconds come from a prescaler. It counts a slow enable pulse (`tick_en`, nominally 100 Hz) and makes one step every `TICKS_PER_SEC` enables. When the count reaches zero, the timer raises a single-cycle timeout strobe. The controller uses this strobe to move to the next question or to apply a penalty. During the last few seconds of either window, an alarm level drives a buzzer enable. A `hold` input pauses the whole timer.

Top module: `round_timer`

## Requirements
- R1: After synchronous reset, the displayed count is 00, and `timeout_o` and `alarm_o` are both 0.
- R2: A `load` pulse sets the count to the phase preset in the next cycle. `phase_sel`=0 selects the buzz window (10). `phase_sel`=1 selects the answer window (30).
- R3: A `load` restarts the prescaler. The count therefore drops by one exactly on the `TICKS_PER_SEC`-th `tick_en` after the load, and on every `TICKS_PER_SEC`-th `tick_en` after that.
- R4: The count is BCD, with `tens_o` and `units_o` each in 0..9. When the units digit is 0, a step sets it to 9 and decrements the tens digit (30→29, 10→09).
- R5: `timeout_o` is high for exactly one cycle: the first cycle in which the count reads 00 after a step from 01.
- R6: `alarm_o` is 1 while the remaining count is 1..5. It is 0 at 6 or more, and 0 at 00.
- R7: While `hold` is 1, `tick_en` has no effect. The count stays unchanged and the prescaler position is kept. After release, only the missing enables are needed to finish the current second.
- R8: A `load` overrides a same-cycle step and an active `hold`. The count shows the new preset, and a full second follows.
- R9: Once the count is 00, further `tick_en` pulses leave it at 00 and raise no `timeout_o` until the next `load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_en | input | 1 | Single-cycle sub-second enable (nominally 100 Hz) |
| load | input | 1 | Load the preset of the selected phase |
| phase_sel | input | 1 | 0 = buzz window, 1 = answer window |
| hold | input | 1 | Freeze count and prescaler |
| tens_o | output | 4 | Tens digit of remaining seconds (BCD) |
| units_o | output | 4 | Units digit of remaining seconds (BCD) |
| timeout_o | output | 1 | One-cycle strobe when the count reaches 00 |
| alarm_o | output | 1 | Buzzer enable during the final seconds |

## Verification
Two functions can fall in the same cycle: a reload, and the enable that would complete a second. The bench drives `load` in the very cycle that carries the `TICKS_PER_SEC`-th enable. It expects the new preset rather than a decremented value. It then expects a full second of enables before the next step, which shows the prescaler was restarted and not left to wrap. The same judgement applies when `load` arrives under `hold`.

// File: rtl/rt_pkg.sv
package rt_pkg;

    typedef enum logic {
        PH_BUZZ   = 1'b0,
        PH_ANSWER = 1'b1
    } phase_e;

    typedef struct packed {
        logic [3:0] tens;
        logic [3:0] units;
    } bcd2_t;

    localparam bcd2_t BCD_ZERO = '0;

    function automatic bcd2_t to_bcd(input int unsigned v);
        bcd2_t r;
        r.tens  = 4'((v / 10) % 10);
        r.units = 4'(v % 10);
        return r;
    endfunction

    function automatic bcd2_t bcd_dec(input bcd2_t c);
        bcd2_t r;
        if (c.units == 4'd0) begin
            r.units = 4'd9;
            r.tens  = c.tens - 4'd1;
        end else begin
            r.units = c.units - 4'd1;
            r.tens  = c.tens;
        end
        return r;
    endfunction

    function automatic logic [6:0] bcd_val(input bcd2_t c);
        return 7'(c.tens) * 7'd10 + 7'(c.units);
    endfunction

endpackage

// File: rtl/rt_tick_div.sv
module rt_tick_div #(
    parameter int TICKS_PER_SEC = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic hold,
    input  logic tick,
    output logic sec_step
);
    localparam int PW = (TICKS_PER_SEC > 2) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICKS_PER_SEC - 1);

    logic [PW-1:0] cnt;
    logic          adv;

    assign adv      = run && tick && !hold;
    assign sec_step = adv && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (adv) begin
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        end
    end

    // R7
    prescale_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !restart) |=> $stable(cnt));

    // R3
    prescale_restart_chk: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

endmodule

// File: rtl/rt_bcd_down.sv
module rt_bcd_down
    import rt_pkg::*;
#(
    parameter int BUZZ_SECS   = 10,
    parameter int ANSWER_SECS = 30
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  phase_e phase,
    input  logic   step,
    output bcd2_t  count,
    output logic   timeout,
    output logic   active
);
    localparam bcd2_t PRE_BUZZ   = to_bcd(BUZZ_SECS);
    localparam bcd2_t PRE_ANSWER = to_bcd(ANSWER_SECS);
    localparam bcd2_t BCD_ONE    = to_bcd(1);

    bcd2_t preset;

    assign preset = (phase == PH_ANSWER) ? PRE_ANSWER : PRE_BUZZ;
    assign active = (count != BCD_ZERO);

    always_ff @(posedge clk) begin
        if (rst) begin
            count   <= BCD_ZERO;
            timeout <= 1'b0;
        end else begin
            timeout <= 1'b0;
            if (load) begin
                count <= preset;
            end else if (step && active) begin
                count   <= bcd_dec(count);
                timeout <= (count == BCD_ONE);
            end
        end
    end

    // R5
    timeout_at_zero_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |-> (count == BCD_ZERO));

    // R5
    timeout_single_chk: assert property (@(posedge clk) disable iff (rst)
        timeout |=> !timeout);

    // R4
    digits_legal_chk: assert property (@(posedge clk) disable iff (rst)
        (count.units <= 4'd9) && (count.tens <= 4'd9));

    // R9
    idle_stays_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !load) |=> (count == BCD_ZERO) && !timeout);

endmodule

// File: rtl/rt_alarm.sv
module rt_alarm
    import rt_pkg::*;
#(
    parameter int ALARM_SECS = 5
) (
    input  bcd2_t count,
    output logic  alarm
);
    logic [6:0] remaining;

    assign remaining = bcd_val(count);
    assign alarm     = (remaining != 7'd0) && (remaining <= 7'(ALARM_SECS));

endmodule

// File: rtl/round_timer.sv
module round_timer
    import rt_pkg::*;
#(
    parameter int TICKS_PER_SEC = 100,
    parameter int BUZZ_SECS     = 10,
    parameter int ANSWER_SECS   = 30,
    parameter int ALARM_SECS    = 5
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_en,
    input  logic       load,
    input  logic       phase_sel,
    input  logic       hold,
    output logic [3:0] tens_o,
    output logic [3:0] units_o,
    output logic       timeout_o,
    output logic       alarm_o
);
    bcd2_t  count;
    logic   active;
    logic   sec_step;
    phase_e phase;

    assign phase = phase_e'(phase_sel);

    rt_tick_div #(
        .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_div (
        .clk      (clk),
        .rst      (rst),
        .restart  (load),
        .run      (active),
        .hold     (hold),
        .tick     (tick_en),
        .sec_step (sec_step)
    );

    rt_bcd_down #(
        .BUZZ_SECS  (BUZZ_SECS),
        .ANSWER_SECS(ANSWER_SECS)
    ) u_cnt (
        .clk     (clk),
        .rst     (rst),
        .load    (load),
        .phase   (phase),
        .step    (sec_step),
        .count   (count),
        .timeout (timeout_o),
        .active  (active)
    );

    rt_alarm #(
        .ALARM_SECS(ALARM_SECS)
    ) u_alarm (
        .count (count),
        .alarm (alarm_o)
    );

    assign tens_o  = count.tens;
    assign units_o = count.units;

    // R7
    hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && !load) |=> $stable(count));

    // R2
    load_preset_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == ($past(phase_sel) ? to_bcd(ANSWER_SECS) : to_bcd(BUZZ_SECS))));

    // R6
    alarm_quiet_on_timeout_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_o |-> !alarm_o);

endmodule

// File: tb/round_timer_tb.sv
module round_timer_tb;
    localparam int TPS = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_en = 1'b0;
    logic       load = 1'b0;
    logic       phase_sel = 1'b0;
    logic       hold = 1'b0;
    logic [3:0] tens_o, units_o;
    logic       timeout_o, alarm_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    round_timer #(
        .TICKS_PER_SEC(TPS),
        .BUZZ_SECS(10),
        .ANSWER_SECS(30),
        .ALARM_SECS(5)
    ) u_dut (
        .clk(clk), .rst(rst), .tick_en(tick_en), .load(load),
        .phase_sel(phase_sel), .hold(hold), .tens_o(tens_o),
        .units_o(units_o), .timeout_o(timeout_o), .alarm_o(alarm_o)
    );

    // {phase, seconds advanced after load, expected count, expected alarm}
    localparam int NV = 10;
    localparam logic [17:0] VEC [NV] = '{
        {1'b0, 8'd0,  8'd10, 1'b0},
        {1'b0, 8'd4,  8'd6,  1'b0},
        {1'b0, 8'd5,  8'd5,  1'b1},
        {1'b0, 8'd9,  8'd1,  1'b1},
        {1'b1, 8'd0,  8'd30, 1'b0},
        {1'b1, 8'd1,  8'd29, 1'b0},
        {1'b1, 8'd20, 8'd10, 1'b0},
        {1'b1, 8'd21, 8'd9,  1'b0},
        {1'b1, 8'd25, 8'd5,  1'b1},
        {1'b1, 8'd29, 8'd1,  1'b1}
    };

    function automatic int shown();
        return int'(tens_o) * 10 + int'(units_o);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic ph);
        @(negedge clk); load = 1'b1; phase_sel = ph;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en = 1'b1;
            @(negedge clk); tick_en = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=expired expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 count", shown(), 0);
        chk("R1 timeout", int'(timeout_o), 0);
        chk("R1 alarm", int'(alarm_o), 0);

        // R2 R3 R4 R6 table walk
        for (int v = 0; v < NV; v++) begin
            do_load(VEC[v][17]);
            ticks(int'(VEC[v][16:9]) * TPS);
            chk("R2/R3/R4 count", shown(), int'(VEC[v][8:1]));
            chk("R6 alarm", int'(alarm_o), int'(VEC[v][0]));
        end

        // R3 step lands exactly on the TPS-th enable
        do_load(1'b0);
        ticks(TPS - 1);
        chk("R3 before full second", shown(), 10);
        ticks(1);
        chk("R3 at full second", shown(), 9);

        // R5 R6 R9 timeout
        do_load(1'b0);
        ticks(9 * TPS + TPS - 1);
        chk("R5 pre-timeout", int'(timeout_o), 0);
        ticks(1);
        chk("R5 timeout strobe", int'(timeout_o), 1);
        chk("R5 count at strobe", shown(), 0);
        chk("R6 alarm at zero", int'(alarm_o), 0);
        @(negedge clk);
        chk("R5 strobe one cycle", int'(timeout_o), 0);
        begin
            int extra = 0;
            for (int i = 0; i < 3 * TPS; i++) begin
                @(negedge clk); tick_en = 1'b1;
                @(negedge clk); tick_en = 1'b0;
                if (timeout_o) extra++;
            end
            chk("R9 no further timeout", extra, 0);
        end
        chk("R9 stays zero", shown(), 0);

        // R7 hold freezes count and prescaler
        do_load(1'b1);
        ticks(TPS - 1);
        hold = 1'b1;
        ticks(2 * TPS + 1);
        chk("R7 frozen count", shown(), 30);
        @(negedge clk); hold = 1'b0;
        ticks(1);
        chk("R7 resumes prescaler", shown(), 29);

        // R8 load coincides with completing enable
        do_load(1'b1);
        ticks(TPS - 1);
        @(negedge clk); tick_en = 1'b1; load = 1'b1; phase_sel = 1'b0;
        @(negedge clk); tick_en = 1'b0; load = 1'b0;
        chk("R8 load beats step", shown(), 10);
        ticks(TPS - 1);
        chk("R8 full second after load", shown(), 10);
        ticks(1);
        chk("R8/R4 borrow 10 to 09", shown(), 9);

        // R8 load under hold
        hold = 1'b1;
        do_load(1'b1);
        chk("R8 load under hold", shown(), 30);
        @(negedge clk); hold = 1'b0;

        finish_run();
    end
endmodule